// File: doc/BRIEF.md
# Non-Pipelined Divider Occupancy Tracker

This block guards a set of divide resources that cannot accept a new operation every cycle. It keeps a short busy timer for each resource. It answers, in the same cycle as a request, whether a divide, square-root or quad-precision operation may issue, and which resource or resources that operation takes. A scheduler drives one request per cycle: a valid strobe and a 3-bit operation class. The tracker returns an accept strobe and a claim mask.

There are seven resources, with claim-mask bit positions fixed as follows:
- Bits 0 to 3 are four floating-point divide lanes.
- Bits 4 and 5 are two fixed-point divide units.
- Bit 6 is one quad/decimal unit.

Each claim holds its resource for a fixed block of cycles (`HOLD_CYCLES`, default 8), whatever the real latency of the operation. Ordinary pipelined operations pass through untouched, whatever the timers hold. The arithmetic itself is done elsewhere.

Top module: `divq_occupancy`

## Requirements
- R1: After synchronous reset all seven resources are free. An idle cycle gives accept 0 and mask 0, and the first request of each divide class is accepted at once with the lowest unit of its group.
- R2: Class code 1 (scalar FP divide or square root) claims exactly one FP lane, the lowest-numbered free one among mask bits 0..3. It is refused (accept 0, mask 0) when all four are busy.
- R3: Class code 2 (vector FP divide) claims lanes 0 and 1 together (mask 0x03) when both are free. Otherwise it claims lanes 2 and 3 (mask 0x0C) when both are free. Otherwise it is refused, even when single lanes are free.
- R4: Class codes 3 and 4 (fixed-point divide, 32 or 64 bit) claim mask bit 4 if free, else bit 5, else are refused.
- R5: Class codes 5 and 6 (quad divide, quad multiply) claim mask bit 6 when it is free, else are refused.
- R6: A resource claimed in cycle c refuses requests for it in cycles c+1 to c+7, and can be claimed again in cycle c+8.
- R7: Class codes 0 (pipelined) and 7 (spare) are accepted whenever valid. They return mask 0 and leave every timer unchanged.
- R8: A cycle with valid low gives accept 0 and mask 0. A cycle with valid low, or a refused request, claims nothing and leaves every timer unchanged.
- R9: Asserting reset in mid-run frees every resource by the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 3 | Operation class code (see R2 to R7) |
| req_accept | output | 1 | Request may issue this cycle |
| claim_mask | output | 7 | Resources taken by the accepted request |

## Verification
The bench aims at the following corner cases:
- **Vector divide with lanes only partly free.** A design that mixes pairs would grant lanes 1 and 2, or grant a half-free pair.
- **Reclaim on exactly the eighth cycle after a claim.** A timer off by one would refuse there, or accept one cycle early.
- **Refused and idle requests between claims.** A design that loads a timer on a refused request would wrongly still be busy eight cycles later.
- **Mid-run reset.** A reset that fails to clear a timer would leave a lane held afterwards.

A long pseudo-random sweep over every class, checked against a cycle-stamped model, catches priority inversions between lanes.

// File: rtl/divq_pkg.sv
`timescale 1ns/1ps
package divq_pkg;

  typedef enum logic [2:0] {
    OP_PIPE   = 3'd0,
    OP_FDIV   = 3'd1,
    OP_VDIV   = 3'd2,
    OP_IDIV32 = 3'd3,
    OP_IDIV64 = 3'd4,
    OP_QDIV   = 3'd5,
    OP_QMUL   = 3'd6,
    OP_SPARE  = 3'd7
  } op_kind_e;

  // True for the classes that need a non-pipelined resource
  function automatic logic needs_unit(input op_kind_e k);
    return (k != OP_PIPE) && (k != OP_SPARE);
  endfunction

endpackage

// File: rtl/divq_timer.sv
`timescale 1ns/1ps
module divq_timer #(
  parameter int unsigned HOLD_CYCLES = 8,
  parameter int unsigned CW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic claim,
  output logic busy
);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (claim)         remain <= LOAD;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  // R6
  claim_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    claim |-> !busy);

  // R6
  hold_loaded_chk: assert property (@(posedge clk) disable iff (rst)
    claim |=> (remain == LOAD));

  // R8
  idle_countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (!claim && busy) |=> (remain == $past(remain) - 1'b1));

  // R8
  stay_free_chk: assert property (@(posedge clk) disable iff (rst)
    (!claim && !busy) |=> !busy);

endmodule

// File: rtl/divq_picker.sv
`timescale 1ns/1ps
module divq_picker
  import divq_pkg::*;
#(
  parameter int unsigned FP_LANES = 4,
  parameter int unsigned FX_UNITS = 2,
  parameter int unsigned NRES = FP_LANES + FX_UNITS + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  op_kind_e        kind,
  input  logic [NRES-1:0] busy,
  output logic            accept,
  output logic [NRES-1:0] mask
);
  localparam int unsigned PAIRS = FP_LANES / 2;

  // Lowest set bit of a free vector, one-hot
  function automatic logic [FP_LANES-1:0] pick_lane(input logic [FP_LANES-1:0] free);
    logic [FP_LANES-1:0] r;
    r = '0;
    for (int i = FP_LANES - 1; i >= 0; i--)
      if (free[i]) begin
        r = '0;
        r[i] = 1'b1;
      end
    return r;
  endfunction

  // Lowest lane pair (2p, 2p+1) with both lanes free
  function automatic logic [FP_LANES-1:0] pick_pair(input logic [FP_LANES-1:0] free);
    logic [FP_LANES-1:0] r;
    r = '0;
    for (int p = PAIRS - 1; p >= 0; p--)
      if (free[2*p] && free[2*p+1]) begin
        r = '0;
        r[2*p +: 2] = 2'b11;
      end
    return r;
  endfunction

  function automatic logic [FX_UNITS-1:0] pick_fx(input logic [FX_UNITS-1:0] free);
    logic [FX_UNITS-1:0] r;
    r = '0;
    for (int i = FX_UNITS - 1; i >= 0; i--)
      if (free[i]) begin
        r = '0;
        r[i] = 1'b1;
      end
    return r;
  endfunction

  logic [FP_LANES-1:0] fp_free;
  logic [FX_UNITS-1:0] fx_free;
  logic                q_free;
  logic [NRES-1:0]     cand;
  logic                wants_unit;
  logic                none_free;

  assign fp_free = ~busy[FP_LANES-1:0];
  assign fx_free = ~busy[FP_LANES +: FX_UNITS];
  assign q_free  = ~busy[NRES-1];

  always_comb begin
    cand = '0;
    unique case (kind)
      OP_FDIV:             cand[FP_LANES-1:0]       = pick_lane(fp_free);
      OP_VDIV:             cand[FP_LANES-1:0]       = pick_pair(fp_free);
      OP_IDIV32, OP_IDIV64: cand[FP_LANES +: FX_UNITS] = pick_fx(fx_free);
      OP_QDIV, OP_QMUL:    cand[NRES-1]             = q_free;
      default:             cand                     = '0;
    endcase
  end

  assign wants_unit = needs_unit(kind);
  assign none_free  = (cand == '0);
  assign accept     = valid && !(wants_unit && none_free);
  assign mask       = (valid && wants_unit) ? cand : '0;

  // R2
  scalar_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && (kind == OP_FDIV)) |-> ($countones(mask) == 1));

  // R3
  vector_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && (kind == OP_VDIV)) |-> ($countones(mask) == 2));

  // R6
  no_busy_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (mask & busy) == '0);

  // R7
  pipe_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !wants_unit) |-> (accept && (mask == '0)));

  // R8
  refuse_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |-> (mask == '0));

endmodule

// File: rtl/divq_occupancy.sv
`timescale 1ns/1ps
module divq_occupancy
  import divq_pkg::*;
#(
  parameter int unsigned FP_LANES    = 4,
  parameter int unsigned FX_UNITS    = 2,
  parameter int unsigned HOLD_CYCLES = 8,
  parameter int unsigned NRES        = FP_LANES + FX_UNITS + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [2:0]      req_kind,
  output logic            req_accept,
  output logic [NRES-1:0] claim_mask
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

  op_kind_e        kind;
  logic [NRES-1:0] busy;
  logic [NRES-1:0] claim;

  assign kind = op_kind_e'(req_kind);

  divq_picker #(
    .FP_LANES (FP_LANES),
    .FX_UNITS (FX_UNITS),
    .NRES     (NRES)
  ) u_picker (
    .clk    (clk),
    .rst    (rst),
    .valid  (req_valid),
    .kind   (kind),
    .busy   (busy),
    .accept (req_accept),
    .mask   (claim)
  );

  for (genvar g = 0; g < NRES; g++) begin : g_res
    divq_timer #(
      .HOLD_CYCLES (HOLD_CYCLES),
      .CW          (CW)
    ) u_timer (
      .clk   (clk),
      .rst   (rst),
      .claim (claim[g]),
      .busy  (busy[g])
    );
  end

  assign claim_mask = claim;

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (busy == '0));

  // R8
  idle_no_claim_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!req_accept && (claim_mask == '0)));

endmodule

// File: tb/divq_occupancy_bench.sv
`timescale 1ns/1ps
module divq_occupancy_bench;
  localparam int NRES = 7;
  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic       req_accept;
  logic [6:0] claim_mask;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int free_at [NRES];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  divq_occupancy u_divq_occupancy (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_accept (req_accept),
    .claim_mask (claim_mask)
  );

  function automatic bit is_free(int i);
    return cyc >= free_at[i];
  endfunction

  // Expected {accept, mask} from the requirements
  function automatic logic [7:0] expect_of(bit v, logic [2:0] k);
    logic [6:0] m;
    m = 7'd0;
    if (!v) return 8'd0;
    case (k)
      3'd1: begin
        for (int i = 0; i < 4; i++)
          if (m == 0 && is_free(i)) m = 7'(1 << i);
      end
      3'd2: begin
        if (is_free(0) && is_free(1))      m = 7'h03;
        else if (is_free(2) && is_free(3)) m = 7'h0C;
      end
      3'd3, 3'd4: begin
        if (is_free(4))      m = 7'h10;
        else if (is_free(5)) m = 7'h20;
      end
      3'd5, 3'd6: if (is_free(6)) m = 7'h40;
      default: return 8'h80;
    endcase
    return {(m != 0), m};
  endfunction

  function automatic string tag_of(bit v, logic [2:0] k);
    if (!v) return "R8";
    case (k)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      3'd5, 3'd6: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: accept/mask actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // One request cycle: drive at negedge, check, then advance the model at posedge
  task automatic step(bit v, logic [2:0] k, string tag);
    logic [7:0] exp;
    @(negedge clk);
    req_valid = v;
    req_kind  = k;
    #1;
    exp = expect_of(v, k);
    check((tag == "") ? tag_of(v, k) : tag, {req_accept, claim_mask}, exp);
    @(posedge clk);
    for (int i = 0; i < NRES; i++)
      if (exp[7] && exp[i]) free_at[i] = cyc + HOLD;
    cyc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NRES; i++) free_at[i] = cyc;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NRES; i++) free_at[i] = 0;
    do_reset();

    // R1: reset state
    step(1'b0, 3'd0, "R1");
    step(1'b1, 3'd2, "R1");
    step(1'b1, 3'd3, "R1");
    step(1'b1, 3'd5, "R1");
    step(1'b1, 3'd1, "R1");

    // R6: quad unit hold window, refused c+1..c+7, free at c+8
    do_reset();
    step(1'b1, 3'd6, "R6");
    for (int j = 1; j < HOLD; j++) step(1'b1, 3'd5, "R6");
    step(1'b1, 3'd5, "R6");

    // R3: lane 1 busy forces pair 2+3, then nothing left for a pair
    do_reset();
    step(1'b1, 3'd1, "R2");
    step(1'b1, 3'd1, "R2");
    step(1'b1, 3'd2, "R3");
    step(1'b1, 3'd2, "R3");
    step(1'b1, 3'd1, "R2");

    // R8: refused and idle cycles must not load timers
    do_reset();
    step(1'b1, 3'd3, "R4");
    step(1'b1, 3'd4, "R4");
    for (int j = 0; j < 4; j++) begin
      step(1'b1, 3'd4, "R8");
      step(1'b0, 3'd3, "R8");
    end
    step(1'b1, 3'd3, "R8");
    step(1'b1, 3'd0, "R7");
    step(1'b1, 3'd7, "R7");
    step(1'b1, 3'd3, "R8");

    // R9: mid-run reset frees held lanes
    for (int j = 0; j < 4; j++) step(1'b1, 3'd1, "R2");
    step(1'b1, 3'd2, "R3");
    do_reset();
    step(1'b1, 3'd2, "R9");
    step(1'b1, 3'd6, "R9");

    // Pseudo-random sweep over all classes
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (n == 1500) do_reset();
      step(lfsr[0] | lfsr[1], lfsr[6:4], "");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule